// File: doc/BRIEF.md
# Serial ADC Host Interface Controller

This block is the host-side master for a 10-bit converter that returns its result over a serial line. It drives an active-low conversion-start line and a serial clock, and it reads the converter's data output. A user-side command port accepts four operations: convert, partial power-down, full power-down and wake. The block turns each command into the matching waveform. For a conversion it captures the ten result bits and returns them with a one-cycle valid strobe, either zero-extended as straight binary or sign-extended as two's complement, depending on a configuration input.

The converter has no mode pins. Its power mode is chosen only by when the start line returns high within a clock frame. A short 8-clock frame puts it into partial power-down. A second short frame takes it from there to full power-down. A frame that keeps the start line low for at least 14 clocks wakes it. The block keeps its own copy of the converter's power state and uses it to refuse conversions while the converter is asleep. The serial clock comes from the system clock through a runtime-programmable even divider. It stays parked low whenever no frame is running.

Top module: `adc_serial_host`

## Requirements
- R1: After reset, adc_cnvst is 1, adc_sclk is 0, busy, done, res_valid and cmd_reject are 0, and pwr_state is 0. The pwr_state encoding is 0 for normal, 1 for partial power-down and 2 for full power-down.
- R2: A convert command (cmd_op = 0) drives adc_cnvst low for one frame that holds exactly 16 adc_sclk rising edges, then returns it high. adc_cnvst is never high while adc_sclk is high.
- R3: During a convert frame, adc_sdata is sampled on the first 10 adc_sclk rising edges, MSB first. Later bits are discarded. With bipolar = 0, result[9:0] holds the 10 bits and result[15:10] is zero. res_valid pulses together with done.
- R4: With bipolar = 1, the 10-bit value is sign-extended into result[15:0], with bit 9 copied into bits 15..10. bipolar is latched when the command is accepted.
- R5: A partial power-down command (cmd_op = 1) runs one frame of 8 adc_sclk rising edges. Entered from normal, it leaves pwr_state at 1. It never raises res_valid.
- R6: A full power-down command (cmd_op = 2) runs two 8-clock frames separated by a gap of at least 4 clock cycles with adc_cnvst high. It leaves pwr_state at 2 and gives a single done pulse.
- R7: A wake command (cmd_op = 3) runs one frame of 16 adc_sclk rising edges, which is at least 14, and leaves pwr_state at 0.
- R8: A convert command presented while pwr_state is not 0 starts no frame. busy stays 0, adc_cnvst stays 1, and cmd_reject pulses for one cycle on the cycle after the request.
- R9: The adc_sclk half period is clk_half system clock cycles, and clk_half = 0 acts as 1. adc_sclk stays at 0 whenever no frame is running.
- R10: busy rises on the cycle after a command is accepted and falls in the cycle where the one-cycle done pulse appears. Commands presented while busy is 1 are ignored. A command presented in the cycle where done is 1 is accepted.
- R11: A partial power-down frame issued while pwr_state is 1 moves pwr_state to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_half | input | 8 | adc_sclk half period in system clock cycles |
| bipolar | input | 1 | 1 = two's complement result, 0 = straight binary |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 convert, 1 partial power-down, 2 full power-down, 3 wake |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_cnvst | output | 1 | Active-low conversion-start / frame line |
| adc_sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse at the end of each command |
| res_valid | output | 1 | One-cycle pulse with a new conversion result |
| result | output | 16 | Formatted conversion result |
| pwr_state | output | 2 | Tracked converter power state |
| cmd_reject | output | 1 | One-cycle pulse when a convert is refused |

## Verification
Two events can fall in the same cycle: the done pulse that ends one command, and the acceptance of the next command. busy drops in the very cycle done is shown. The bench therefore raises a new partial power-down request exactly in the cycle where done is high, and then checks that the start line goes low and busy rises one cycle later. It then checks that the new frame has 8 clocks and ends in the partial state. A second case sends a request in the middle of a frame and confirms that it leaves no trace in the frame count or the power state.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [1:0] {
    OP_CONV = 2'd0,
    OP_PPD  = 2'd1,
    OP_FPD  = 2'd2,
    OP_WAKE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PS_NORM = 2'd0,
    PS_PART = 2'd1,
    PS_FULL = 2'd2
  } pstate_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_GAP   = 2'd2
  } seq_e;
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             tick;

  assign lim  = (half == '0) ? '0 : half - 1'b1;
  assign tick = run && (cnt == lim);
  assign rise = tick && !sclk;
  assign fall = tick && sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R9: clock parks low once the frame stops
  p_sclk_park_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sclk);
endmodule

// File: rtl/adc_rx_capture.sv
module adc_rx_capture #(
  parameter int RES_BITS = 10,
  parameter int OUT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             rise,
  input  logic             sdata,
  input  logic             cap_en,
  input  logic             bip,
  input  logic             frame_end,
  output logic [OUT_W-1:0] result,
  output logic             valid
);
  localparam int RC_W = $clog2(RES_BITS + 1);
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RES_BITS);
  localparam int EXT_W = OUT_W - RES_BITS;

  logic [RES_BITS-1:0] sh;
  logic [RC_W-1:0]     rcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      rcnt   <= '0;
      result <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (!run) begin
        rcnt <= '0;
      end else if (rise && rcnt < RC_LAST) begin
        sh   <= {sh[RES_BITS-2:0], sdata};
        rcnt <= rcnt + 1'b1;
      end
      if (frame_end && cap_en) begin
        valid <= 1'b1;
        if (bip) result <= {{EXT_W{sh[RES_BITS-1]}}, sh};
        else     result <= {{EXT_W{1'b0}}, sh};
      end
    end
  end

  // R3: trailing bits leave the captured word untouched
  p_tail_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (run && rise && rcnt == RC_LAST) |=> $stable(sh));
  // R5: a result only follows a capturing frame
  p_valid_capture_r5: assert property (@(posedge clk) disable iff (rst)
    valid |-> $past(cap_en));
endmodule

// File: rtl/adc_pwr_track.sv
module adc_pwr_track
  import adc_host_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    end_evt,
  input  logic    is_pd,
  input  logic    is_wake,
  output pstate_e state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PS_NORM;
    end else if (end_evt) begin
      if (is_wake) begin
        state <= PS_NORM;
      end else if (is_pd) begin
        case (state)
          PS_NORM: state <= PS_PART;
          default: state <= PS_FULL;
        endcase
      end
    end
  end

  // R7: a wake frame always returns to normal
  p_wake_norm_r7: assert property (@(posedge clk) disable iff (rst)
    (end_evt && is_wake) |=> state == PS_NORM);
  // R11: a short frame from partial goes to full
  p_pd_deeper_r11: assert property (@(posedge clk) disable iff (rst)
    (end_evt && is_pd && state == PS_PART) |=> state == PS_FULL);
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
  import adc_host_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int RES_BITS  = 10,
  parameter int OUT_W     = 16,
  parameter int CONV_CLKS = 16,
  parameter int PD_CLKS   = 8,
  parameter int WAKE_CLKS = 16,
  parameter int GAP_CYC   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] clk_half,
  input  logic             bipolar,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             adc_sdata,
  output logic             adc_cnvst,
  output logic             adc_sclk,
  output logic             busy,
  output logic             done,
  output logic             res_valid,
  output logic [OUT_W-1:0] result,
  output logic [1:0]       pwr_state,
  output logic             cmd_reject
);
  localparam int MAX_A = (CONV_CLKS > WAKE_CLKS) ? CONV_CLKS : WAKE_CLKS;
  localparam int MAX_L = (MAX_A > PD_CLKS) ? MAX_A : PD_CLKS;
  localparam int CNT_W = $clog2(MAX_L + 1);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);

  function automatic logic [CNT_W-1:0] len_of(input op_e o);
    case (o)
      OP_CONV: return CNT_W'(CONV_CLKS);
      OP_WAKE: return CNT_W'(WAKE_CLKS);
      default: return CNT_W'(PD_CLKS);
    endcase
  endfunction

  seq_e             st;
  op_e              op_q;
  op_e              op_in;
  logic             bip_q;
  logic             second_pending;
  logic [CNT_W-1:0] fall_cnt;
  logic [CNT_W-1:0] frame_len;
  logic [GAP_W-1:0] gap_cnt;
  logic             run;
  logic             sclk_rise;
  logic             sclk_fall;
  logic             frame_end;
  logic             rej_now;
  logic             accept;
  pstate_e          ps;

  assign op_in     = op_e'(cmd_op);
  assign run       = (st == ST_FRAME);
  assign rej_now   = cmd_valid && st == ST_IDLE && op_in == OP_CONV && ps != PS_NORM;
  assign accept    = cmd_valid && st == ST_IDLE && !rej_now;
  assign frame_end = run && sclk_fall && (fall_cnt == frame_len - 1'b1);
  assign pwr_state = ps;

  adc_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .half (clk_half),
    .sclk (adc_sclk),
    .rise (sclk_rise),
    .fall (sclk_fall)
  );

  adc_rx_capture #(.RES_BITS(RES_BITS), .OUT_W(OUT_W)) u_rx (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .rise      (sclk_rise),
    .sdata     (adc_sdata),
    .cap_en    (op_q == OP_CONV),
    .bip       (bip_q),
    .frame_end (frame_end),
    .result    (result),
    .valid     (res_valid)
  );

  adc_pwr_track u_pwr (
    .clk     (clk),
    .rst     (rst),
    .end_evt (frame_end),
    .is_pd   (op_q == OP_PPD || op_q == OP_FPD),
    .is_wake (op_q == OP_WAKE),
    .state   (ps)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st             <= ST_IDLE;
      op_q           <= OP_CONV;
      bip_q          <= 1'b0;
      second_pending <= 1'b0;
      fall_cnt       <= '0;
      frame_len      <= '0;
      gap_cnt        <= '0;
      adc_cnvst      <= 1'b1;
      busy           <= 1'b0;
      done           <= 1'b0;
      cmd_reject     <= 1'b0;
    end else begin
      done       <= 1'b0;
      cmd_reject <= rej_now;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st             <= ST_FRAME;
            op_q           <= op_in;
            bip_q          <= bipolar;
            frame_len      <= len_of(op_in);
            second_pending <= (op_in == OP_FPD);
            fall_cnt       <= '0;
            adc_cnvst      <= 1'b0;
            busy           <= 1'b1;
          end
        end
        ST_FRAME: begin
          if (sclk_fall) fall_cnt <= fall_cnt + 1'b1;
          if (frame_end) begin
            adc_cnvst <= 1'b1;
            fall_cnt  <= '0;
            if (second_pending) begin
              st             <= ST_GAP;
              gap_cnt        <= '0;
              second_pending <= 1'b0;
            end else begin
              st   <= ST_IDLE;
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end
        ST_GAP: begin
          gap_cnt <= gap_cnt + 1'b1;
          if (gap_cnt == GAP_LAST) begin
            st        <= ST_FRAME;
            adc_cnvst <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: done is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3: a result is only presented at the end of a command
  p_valid_done_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> done);
  // R8: refusals only happen while asleep and start nothing
  p_reject_asleep_r8: assert property (@(posedge clk) disable iff (rst)
    cmd_reject |-> (ps != PS_NORM && !busy));
  // R2: the start line is never high with the clock high
  p_cnvst_sclk_r2: assert property (@(posedge clk) disable iff (rst)
    adc_cnvst |-> !adc_sclk);
endmodule

// File: tb/tb_adc_serial_host.sv
module tb_adc_serial_host;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  clk_half = 8'd2;
  logic        bipolar = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        adc_sdata = 1'b1;
  logic        adc_cnvst, adc_sclk, busy, done, res_valid, cmd_reject;
  logic [15:0] result;
  logic [1:0]  pwr_state;

  adc_serial_host dut (
    .clk(clk), .rst(rst), .clk_half(clk_half), .bipolar(bipolar),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .adc_sdata(adc_sdata),
    .adc_cnvst(adc_cnvst), .adc_sclk(adc_sclk), .busy(busy), .done(done),
    .res_valid(res_valid), .result(result), .pwr_state(pwr_state),
    .cmd_reject(cmd_reject)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit fin = 0;
  int rises = 0;
  int frames = 0;
  int cyc = 0;
  int last_rise = 0;
  int period = 0;
  int idx = 0;
  logic [15:0] word = '0;
  logic got_done, got_valid;
  logic [15:0] got_res;

  always @(posedge clk) cyc++;
  always @(posedge adc_sclk) begin
    if (!adc_cnvst) rises++;
    period = cyc - last_rise;
    last_rise = cyc;
  end
  always @(negedge adc_cnvst) begin
    frames++;
    idx = 0;
    adc_sdata = word[15];
  end
  always @(negedge adc_sclk) begin
    if (!adc_cnvst) begin
      idx++;
      adc_sdata = (idx < 16) ? word[15-idx] : 1'b0;
    end
  end
  always @(posedge adc_cnvst) adc_sdata = 1'b1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    got_done = 0;
    for (int i = 0; i < 3000 && !got_done; i++) begin
      @(negedge clk);
      if (done) begin
        got_done = 1;
        got_valid = res_valid;
        got_res = result;
      end
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic bip, input logic [9:0] d);
    if (op == 2'd0) word = {d, 2'b11, 4'b0110};
    else            word = {3'b000, d[9:5], 8'hFF};
    rises = 0;
    frames = 0;
    cmd_op = op;
    bipolar = bip;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic        bip;
    logic [9:0]  data;
    logic [15:0] exp_res;
    logic [1:0]  exp_ps;
    logic        exp_val;
    logic [4:0]  exp_rises;
    logic [1:0]  exp_frames;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 10'h2A5, 16'h02A5, 2'd0, 1'b1, 5'd16, 2'd1},
    '{2'd0, 1'b1, 10'h2A5, 16'hFEA5, 2'd0, 1'b1, 5'd16, 2'd1},
    '{2'd0, 1'b1, 10'h155, 16'h0155, 2'd0, 1'b1, 5'd16, 2'd1},
    '{2'd0, 1'b0, 10'h3FF, 16'h03FF, 2'd0, 1'b1, 5'd16, 2'd1},
    '{2'd1, 1'b0, 10'h3FF, 16'h0000, 2'd1, 1'b0, 5'd8,  2'd1},
    '{2'd1, 1'b0, 10'h000, 16'h0000, 2'd2, 1'b0, 5'd8,  2'd1},
    '{2'd3, 1'b0, 10'h000, 16'h0000, 2'd0, 1'b0, 5'd16, 2'd1},
    '{2'd2, 1'b0, 10'h3FF, 16'h0000, 2'd2, 1'b0, 5'd16, 2'd2},
    '{2'd3, 1'b0, 10'h000, 16'h0000, 2'd0, 1'b0, 5'd16, 2'd1},
    '{2'd0, 1'b1, 10'h200, 16'hFE00, 2'd0, 1'b1, 5'd16, 2'd1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cnvst", adc_cnvst, 1);
    chk("R1 sclk", adc_sclk, 0);
    chk("R1 busy/done/valid/rej", {busy, done, res_valid, cmd_reject}, 0);
    chk("R1 pwr_state", pwr_state, 0);

    for (int v = 0; v < NV; v++) begin
      issue(VEC[v].op, VEC[v].bip, VEC[v].data);
      chk($sformatf("R10 busy after accept v%0d", v), {busy, adc_cnvst}, 2'b10);
      wait_done();
      chk($sformatf("R10 done seen v%0d", v), got_done, 1);
      chk($sformatf("R2 R5 R7 rises v%0d", v), rises, VEC[v].exp_rises);
      chk($sformatf("R6 frames v%0d", v), frames, VEC[v].exp_frames);
      chk($sformatf("R5 R6 R11 pwr_state v%0d", v), pwr_state, VEC[v].exp_ps);
      chk($sformatf("R3 R5 valid v%0d", v), got_valid, VEC[v].exp_val);
      if (VEC[v].exp_val)
        chk($sformatf("R3 R4 result v%0d", v), got_res, VEC[v].exp_res);
      @(negedge clk);
      chk($sformatf("R10 done single v%0d", v), done, 0);
      chk($sformatf("R9 sclk parked v%0d", v), adc_sclk, 0);
    end

    // R8: convert refused while asleep
    issue(2'd1, 1'b0, 10'h0);
    wait_done();
    chk("R5 entered partial", pwr_state, 1);
    issue(2'd0, 1'b0, 10'h155);
    chk("R8 reject pulse", cmd_reject, 1);
    chk("R8 no frame", {busy, adc_cnvst}, 2'b01);
    @(negedge clk);
    chk("R8 reject single", cmd_reject, 0);
    repeat (20) @(negedge clk);
    chk("R8 no frames", frames, 0);
    issue(2'd3, 1'b0, 10'h0);
    wait_done();
    chk("R7 wake normal", pwr_state, 0);

    // R4: bipolar latched at accept
    issue(2'd0, 1'b1, 10'h301);
    bipolar = 1'b0;
    wait_done();
    chk("R4 latched bipolar", got_res, 16'hFF01);

    // R10: command in same cycle as done is accepted
    issue(2'd0, 1'b0, 10'h0AA);
    wait_done();
    chk("R3 result before overlap", got_res, 16'h00AA);
    word = {3'b000, 5'h1F, 8'hFF};
    rises = 0;
    frames = 0;
    cmd_op = 2'd1;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 accept on done cycle", {busy, adc_cnvst}, 2'b10);
    wait_done();
    chk("R10 overlap rises", rises, 8);
    chk("R10 overlap partial", pwr_state, 1);
    issue(2'd3, 1'b0, 10'h0);
    wait_done();

    // R10: request while busy is ignored
    issue(2'd0, 1'b0, 10'h123);
    repeat (10) @(negedge clk);
    cmd_op = 2'd1;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    chk("R10 busy-ignore result", got_res, 16'h0123);
    repeat (20) @(negedge clk);
    chk("R10 busy-ignore state", pwr_state, 0);
    chk("R10 busy-ignore frames", frames, 1);
    chk("R10 busy-ignore idle", {busy, adc_cnvst}, 2'b01);

    // R9: divider
    clk_half = 8'd3;
    issue(2'd0, 1'b0, 10'h011);
    wait_done();
    chk("R9 period half=3", period, 6);
    chk("R3 result half=3", got_res, 16'h0011);
    clk_half = 8'd0;
    issue(2'd0, 1'b0, 10'h3C3);
    wait_done();
    chk("R9 period half=0", period, 2);
    chk("R2 rises half=0", rises, 16);
    chk("R3 result half=0", got_res, 16'h03C3);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule